// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block scans the byte stream of received Ethernet frames for the magic wake pattern addressed to this station. The pattern is a run of `0xFF` sync bytes followed directly by sixteen unbroken copies of the station's 48-bit MAC address. The pattern may start anywhere in the frame, normally somewhere in the payload after the two address fields. A match found in the middle of a frame is only held as pending. It turns into a wake event only when the frame ends with a passing CRC indication.

The receive path delivers one byte per `rx_valid` cycle. `rx_sof` marks the first byte of a frame. `rx_eof` marks the last byte, and `rx_good` is read together with it. Detection is armed either by the software enable (at full power) or automatically whenever the light-sleep state is selected. A wake event produces a one-cycle pulse and sets a sticky status bit, which stays set until software clears it.

Top module: `wol_magic_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `wake_pulse` and `wake_status` are 0.
- R2: A pattern of six `0xFF` bytes followed at once by 16 back-to-back copies of `station_mac` is detected at any offset in the frame. Each address copy is matched with byte 0 = `station_mac[47:40]` first, down to `station_mac[7:0]` last. Seven or more `0xFF` bytes before the address still form a valid sync.
- R3: No detection occurs if any byte is inserted between address copies, if only 15 copies follow the sync, or if the address differs from `station_mac`.
- R4: A wrong byte inside the sync or address run restarts the search. If that byte is `0xFF`, it counts as the first byte of a new sync run, so it plus five more `0xFF` bytes form a full sync, while it plus four do not.
- R5: `wake_pulse` is 1 for exactly the one cycle after the `rx_eof` byte is accepted, and only if a pattern was completed in that frame and `rx_good` was 1 on that byte.
- R6: A frame that ends with `rx_good` = 0 discards its pending match. The pending match never carries into the next frame.
- R7: A byte with `rx_sof` = 1 clears any partially matched sync or address run, so a pattern split across two frames is not detected.
- R8: Detection is armed when `pwr_sleep` = 1 (light sleep, regardless of `magic_en`) or when `pwr_sleep` = 0 and `magic_en` = 1. If it is not armed, a valid magic frame produces no wake.
- R9: `wake_status` is set in the same cycle as `wake_pulse` and holds through later frames until a `stat_clr` cycle clears it. A set and a clear in the same cycle leave it set.
- R10: `wake_pulse` never stays high for two consecutive cycles and never rises without a preceding end-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe on the receive stream |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_good | input | 1 | CRC passed, qualified by `rx_eof` |
| station_mac | input | 48 | Station address, byte 0 in bits 47:40 |
| pwr_sleep | input | 1 | 0 = full power, 1 = light sleep |
| magic_en | input | 1 | Software enable for full-power detection |
| stat_clr | input | 1 | Clears the sticky status |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_status | output | 1 | Sticky wake indication |

## Verification
The hardest case to reach from the ports is a search that has to recover in the middle of an address run. The failing byte must be `0xFF` and must seed a new sync run, and whether a wake follows depends on exactly one extra sync byte. The stimulus builds frames that break the third address copy with an `0xFF` byte. It then sends either five or four further `0xFF` bytes before a full set of sixteen copies, which pins down the boundary from both sides. A second hard case is a match split by a new start-of-frame. The bench reaches it by dropping the end-of-frame marker from one frame and starting the next frame with the remaining address copies.

// File: rtl/wol_pkg.sv
package wol_pkg;
  typedef enum logic {
    PH_SYNC = 1'b0,
    PH_ADDR = 1'b1
  } match_phase_e;
endpackage

// File: rtl/wol_arm_ctrl.sv
module wol_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pwr_sleep,
  input  logic magic_en,
  output logic armed
);
  // light sleep arms unconditionally; full power follows the software enable
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= pwr_sleep | magic_en;
  end
endmodule

// File: rtl/wol_pattern_match.sv
module wol_pattern_match
  import wol_pkg::*;
#(
  parameter int MAC_BYTES = 6,
  parameter int SYNC_LEN  = 6,
  parameter int REPEATS   = 16,
  parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_vld,
  input  logic                   byte_sof,
  input  logic [7:0]             byte_dat,
  input  logic [8*MAC_BYTES-1:0] station_mac,
  output logic                   hit
);
  localparam int RUN_W = $clog2(SYNC_LEN + 1);
  localparam int IDX_W = $clog2(MAC_BYTES);
  localparam int REP_W = $clog2(REPEATS);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAC_BYTES - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic [7:0] mac_arr [MAC_BYTES];
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    assign mac_arr[g] = station_mac[8*(MAC_BYTES-1-g) +: 8];
  end

  match_phase_e     ph_q, ph_c, ph_n;
  logic [RUN_W-1:0] run_q, run_c, run_n;
  logic [IDX_W-1:0] idx_q, idx_c, idx_n;
  logic [REP_W-1:0] rep_q, rep_c, rep_n;
  logic             restart;

  assign restart = byte_vld & byte_sof;

  always_comb begin
    ph_c  = restart ? PH_SYNC : ph_q;
    run_c = restart ? '0 : run_q;
    idx_c = restart ? '0 : idx_q;
    rep_c = restart ? '0 : rep_q;
    ph_n  = ph_c;
    run_n = run_c;
    idx_n = idx_c;
    rep_n = rep_c;
    hit   = 1'b0;
    if (byte_vld) begin
      if (ph_c == PH_SYNC) begin
        if (byte_dat == SYNC_BYTE) begin
          run_n = (run_c == RUN_FULL) ? run_c : run_c + RUN_W'(1);
        end else if (run_c == RUN_FULL && byte_dat == mac_arr[0]) begin
          ph_n  = PH_ADDR;
          idx_n = IDX_W'(1);
          rep_n = '0;
          run_n = '0;
        end else begin
          run_n = '0;
        end
      end else begin
        if (byte_dat == mac_arr[idx_c]) begin
          if (idx_c == IDX_LAST) begin
            idx_n = '0;
            if (rep_c == REP_LAST) begin
              hit   = 1'b1;
              ph_n  = PH_SYNC;
              run_n = '0;
              rep_n = '0;
            end else begin
              rep_n = rep_c + REP_W'(1);
            end
          end else begin
            idx_n = idx_c + IDX_W'(1);
          end
        end else begin
          ph_n  = PH_SYNC;
          idx_n = '0;
          rep_n = '0;
          run_n = (byte_dat == SYNC_BYTE) ? RUN_W'(1) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_SYNC;
      run_q <= '0;
      idx_q <= '0;
      rep_q <= '0;
    end else begin
      ph_q  <= ph_n;
      run_q <= run_n;
      idx_q <= idx_n;
      rep_q <= rep_n;
    end
  end
endmodule

// File: rtl/wol_wake_out.sv
module wol_wake_out (
  input  logic clk,
  input  logic rst,
  input  logic byte_vld,
  input  logic byte_sof,
  input  logic byte_eof,
  input  logic frame_good,
  input  logic hit,
  input  logic armed,
  input  logic stat_clr,
  output logic wake_pulse,
  output logic wake_status
);
  logic pend_q;
  logic found;
  logic fire;

  assign found = hit | (pend_q & ~byte_sof);
  assign fire  = byte_vld & byte_eof & frame_good & armed & found;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      wake_pulse  <= 1'b0;
      wake_status <= 1'b0;
    end else begin
      if (byte_vld) begin
        if (byte_eof)      pend_q <= 1'b0;
        else if (hit)      pend_q <= 1'b1;
        else if (byte_sof) pend_q <= 1'b0;
      end
      wake_pulse <= fire;
      if (fire)          wake_status <= 1'b1;
      else if (stat_clr) wake_status <= 1'b0;
    end
  end
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int MAC_BYTES = 6,
  parameter int SYNC_LEN  = 6,
  parameter int REPEATS   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic                   rx_sof,
  input  logic                   rx_eof,
  input  logic [7:0]             rx_data,
  input  logic                   rx_good,
  input  logic [8*MAC_BYTES-1:0] station_mac,
  input  logic                   pwr_sleep,
  input  logic                   magic_en,
  input  logic                   stat_clr,
  output logic                   wake_pulse,
  output logic                   wake_status
);
  logic armed;
  logic hit;

  wol_arm_ctrl u_arm (
    .clk       (clk),
    .rst       (rst),
    .pwr_sleep (pwr_sleep),
    .magic_en  (magic_en),
    .armed     (armed)
  );

  wol_pattern_match #(
    .MAC_BYTES (MAC_BYTES),
    .SYNC_LEN  (SYNC_LEN),
    .REPEATS   (REPEATS)
  ) u_match (
    .clk         (clk),
    .rst         (rst),
    .byte_vld    (rx_valid),
    .byte_sof    (rx_sof),
    .byte_dat    (rx_data),
    .station_mac (station_mac),
    .hit         (hit)
  );

  wol_wake_out u_out (
    .clk         (clk),
    .rst         (rst),
    .byte_vld    (rx_valid),
    .byte_sof    (rx_sof),
    .byte_eof    (rx_eof),
    .frame_good  (rx_good),
    .hit         (hit),
    .armed       (armed),
    .stat_clr    (stat_clr),
    .wake_pulse  (wake_pulse),
    .wake_status (wake_status)
  );
endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_good,
  input logic pwr_sleep,
  input logic magic_en,
  input logic stat_clr,
  input logic wake_pulse,
  input logic wake_status
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!wake_pulse && !wake_status));

  // R5
  pulse_after_good_eof_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(rx_valid && rx_eof && rx_good));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R8
  pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $past(pwr_sleep || magic_en, 2));

  // R9
  status_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> wake_status);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_status && !stat_clr) |=> wake_status);

  // R9
  status_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_status) |-> $past(stat_clr));
endmodule

bind wol_magic_detect wol_magic_detect_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .rx_eof      (rx_eof),
  .rx_good     (rx_good),
  .pwr_sleep   (pwr_sleep),
  .magic_en    (magic_en),
  .stat_clr    (stat_clr),
  .wake_pulse  (wake_pulse),
  .wake_status (wake_status)
);

// File: tb/wol_magic_detect_tb_top.sv
`timescale 1ns/1ps
module wol_magic_detect_tb_top;
  localparam logic [47:0] MAC   = 48'h02_1A_3C_4D_5E_6F;
  localparam logic [47:0] OTHER = 48'h02_1A_3C_4D_5E_70;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        pwr_sleep = 1'b0, magic_en = 1'b1, stat_clr = 1'b0;
  logic        wake_pulse, wake_status;

  int checks = 0;
  int fails  = 0;
  logic [7:0] fq[$];
  bit         exp_q[$];
  string      tag_q[$];
  logic       eof_seen = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wol_magic_detect dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_good(rx_good), .station_mac(MAC), .pwr_sleep(pwr_sleep),
    .magic_en(magic_en), .stat_clr(stat_clr), .wake_pulse(wake_pulse),
    .wake_status(wake_status)
  );

  always @(posedge clk) eof_seen <= rx_valid & rx_eof;

  // monitor: one expected wake value per end-of-frame byte
  always @(negedge clk) begin
    if (!rst) begin
      if (eof_seen) begin
        bit    e;
        string t;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
        t = (tag_q.size() > 0) ? tag_q.pop_front() : "R5";
        checks++;
        if (wake_pulse !== e) begin
          fails++;
          $display("FAIL %s: wake_pulse actual %0b expected %0b", t, wake_pulse, e);
        end
      end else if (wake_pulse !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R10: wake_pulse actual %0b expected 0 without end of frame", wake_pulse);
      end
    end
  end

  task automatic put_sync(int n);
    repeat (n) fq.push_back(8'hFF);
  endtask

  task automatic put_mac(logic [47:0] m, int reps);
    for (int r = 0; r < reps; r++)
      for (int b = 0; b < 6; b++) fq.push_back(m[8*(5-b) +: 8]);
  endtask

  task automatic put_hdr();
    for (int b = 0; b < 12; b++) fq.push_back(8'h10 + 8'(b));
    fq.push_back(8'h08);
    fq.push_back(8'h42);
  endtask

  task automatic put_crc();
    fq.push_back(8'h5A); fq.push_back(8'hC3); fq.push_back(8'h17); fq.push_back(8'h88);
  endtask

  task automatic send_frame(bit term, bit good, bit exp, string tag);
    int n;
    n = fq.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = term && (i == n - 1);
      rx_good  = term && (i == n - 1) && good;
      rx_data  = fq[i];
      if (term && i == n - 1) begin
        exp_q.push_back(exp);
        tag_q.push_back(tag);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_data = 8'h00;
    fq.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_status(bit exp, string tag);
    @(negedge clk);
    checks++;
    if (wake_status !== exp) begin
      fails++;
      $display("FAIL %s: wake_status actual %0b expected %0b", tag, wake_status, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wake_pulse !== 1'b0 || wake_status !== 1'b0) begin
      fails++;
      $display("FAIL R1: outputs actual %0b%0b expected 00", wake_pulse, wake_status);
    end
    rst = 1'b0;
    chk_status(1'b0, "R1");

    // R2 basic magic frame, full power, enabled
    put_hdr(); put_sync(6); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 1, "R2");
    chk_status(1'b1, "R9");
    // R9 sticky across a plain frame
    put_hdr(); put_crc();
    send_frame(1, 1, 0, "R5");
    chk_status(1'b1, "R9");
    pulse_clear();
    chk_status(1'b0, "R9");

    // R2 long sync run
    put_hdr(); put_sync(9); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 1, "R2");
    pulse_clear();

    // R3 15 copies, gap, wrong address
    put_hdr(); put_sync(6); put_mac(MAC, 15); put_crc();
    send_frame(1, 1, 0, "R3");
    put_hdr(); put_sync(6); put_mac(MAC, 1); fq.push_back(8'h00); put_mac(MAC, 15); put_crc();
    send_frame(1, 1, 0, "R3");
    put_hdr(); put_sync(6); put_mac(OTHER, 16); put_crc();
    send_frame(1, 1, 0, "R3");

    // R4 restart: failing 0xFF plus five more forms a sync
    put_hdr(); put_sync(6); put_mac(MAC, 2);
    fq.push_back(8'h02); fq.push_back(8'h1A); fq.push_back(8'h3C);
    put_sync(6); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 1, "R4");
    // R4 failing 0xFF plus four more is too short
    put_hdr(); put_sync(6); put_mac(MAC, 2);
    fq.push_back(8'h02); fq.push_back(8'h1A); fq.push_back(8'h3C);
    put_sync(5); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 0, "R4");

    // R6 bad CRC, then clean frame must not inherit the match
    put_hdr(); put_sync(6); put_mac(MAC, 16); put_crc();
    send_frame(1, 0, 0, "R6");
    put_hdr(); put_crc();
    send_frame(1, 1, 0, "R6");

    // R7 pattern split by a new start of frame
    put_hdr(); put_sync(6); put_mac(MAC, 8);
    send_frame(0, 0, 0, "R7");
    put_mac(MAC, 8); put_crc();
    send_frame(1, 1, 0, "R7");
    chk_status(1'b1, "R9");
    pulse_clear();

    // R8 full power, disabled: no wake
    magic_en = 1'b0;
    repeat (3) @(negedge clk);
    put_hdr(); put_sync(6); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 0, "R8");
    chk_status(1'b0, "R8");
    // R8 light sleep arms regardless of enable
    pwr_sleep = 1'b1;
    repeat (3) @(negedge clk);
    put_hdr(); put_sync(7); put_mac(MAC, 16); put_crc();
    send_frame(1, 1, 1, "R8");
    chk_status(1'b1, "R8");

    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5: pending expectations actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule